// File: doc/BRIEF.md
# Serial Triple-One Run Detector

This block watches a one-bit serial stream. It samples the stream on every rising clock edge and raises a pulse when the stream holds a 1 for three consecutive samples. It keeps only a count of the ones it has already seen, and that count can be 0, 1 or 2. The third 1 is recognised on the fly: the hit output is a Mealy decode of the stored count together with the live input bit, so the pulse appears in the same cycle as that third 1.

Detection does not overlap. After a hit the count returns to zero, so a fourth consecutive 1 counts as the first bit of a fresh run. A continuous stream of ones therefore produces a hit on every third bit. A 0 in the stream clears the count. A synchronous active-high reset also clears the count, and reset wins over the data bit in the same cycle.

The count is held in a 2-bit register with the codes 00, 01 and 10 for zero, one and two ones seen. The spare code 11 falls back to zero on the next edge.

Top module: `triple_one_detector`

## Requirements
- R1: While `sync_rst` is 1, `run_hit` is 0. A rising edge with `sync_rst` at 1 leaves the count at zero, so two ones that follow the reset do not raise `run_hit`, and the third one does.
- R2: From a count of zero, a 1 moves the count to one. From a count of one, a 1 moves the count to two. `run_hit` stays 0 on both of these bits.
- R3: When the count is two and `bit_in` is 1, `run_hit` is 1 combinationally in that same cycle, and the next rising edge returns the count to zero.
- R4: A 0 on `bit_in` keeps `run_hit` at 0 and returns the count to zero from any count. A 0 at count zero leaves the count at zero.
- R5: Detection does not overlap. In an unbroken stream of ones after a count of zero, `run_hit` is 1 on the 3rd, 6th, 9th … bit and 0 on every other bit, including the 4th.
- R6: `sync_rst` takes priority over `bit_in`. A 1 on `bit_in` in a reset cycle does not advance the count, even when the count was two.
- R7: `run_hit` is 1 only when the last two bits accepted since the most recent reset, zero or hit were both 1 and `bit_in` is 1. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count register updates on its rising edge |
| sync_rst | input | 1 | Synchronous active-high reset; clears the count |
| bit_in | input | 1 | Serial data bit, sampled on each rising edge |
| run_hit | output | 1 | Combinational pulse on the third 1 of a run |

## Verification
The block has no parameters, so the bench builds it as it stands. The machine has only three reachable counts, which makes a near-exhaustive sweep cheap. From reset, the bench drives every bit pattern of length one to eight, with no reset and then with a reset asserted on the final bit. This covers every transition from every count, covers reset arriving in each count, and covers runs long enough to show the non-overlapping restart after a hit. A directed walk through each transition in turn, followed by a long run of ones, checks the every-third-bit cadence.

// File: rtl/triple_one_detector.sv
module triple_one_detector (
  input  logic clk_i,
  input  logic sync_rst,
  input  logic bit_in,
  output logic run_hit
);

  typedef enum logic [1:0] {
    CNT0    = 2'b00,
    CNT1    = 2'b01,
    CNT2    = 2'b10,
    CNT_BAD = 2'b11
  } cnt_e;

  cnt_e state, state_nx;

  always_comb begin
    case (state)
      CNT0:    state_nx = bit_in ? CNT1 : CNT0;
      CNT1:    state_nx = bit_in ? CNT2 : CNT0;
      CNT2:    state_nx = bit_in ? CNT0 : CNT0;
      default: state_nx = CNT0;
    endcase
  end

  assign run_hit = !sync_rst && (state == CNT2) && bit_in;

  always_ff @(posedge clk_i) begin
    if (sync_rst) state <= CNT0;
    else          state <= state_nx;
  end

endmodule

// File: rtl/triple_one_detector_chk.sv
module triple_one_detector_chk (
  input logic       clk_i,
  input logic       sync_rst,
  input logic       bit_in,
  input logic       run_hit,
  input logic [1:0] state
);

  // R1: no hit while reset is held
  always_comb begin
    if (sync_rst == 1'b1) a_rst_quiet_r1: assert (run_hit == 1'b0);
  end

  p_rst_zero_r1: assert property (@(posedge clk_i) disable iff (sync_rst)
    $past(sync_rst) |-> state == 2'b00);

  p_adv_one_r2: assert property (@(posedge clk_i) disable iff (sync_rst)
    (state == 2'b00 && bit_in) |=> state == 2'b01);

  p_adv_two_r2: assert property (@(posedge clk_i) disable iff (sync_rst)
    (state == 2'b01 && bit_in) |=> state == 2'b10);

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (sync_rst)
    run_hit |=> state == 2'b00);

  p_zero_clears_r4: assert property (@(posedge clk_i) disable iff (sync_rst)
    !bit_in |=> state == 2'b00);

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (sync_rst)
    run_hit |=> !run_hit);

  p_legal_code_r7: assert property (@(posedge clk_i) disable iff (sync_rst)
    $onehot0(state));

endmodule

bind triple_one_detector triple_one_detector_chk u_chk (
  .clk_i    (clk_i),
  .sync_rst (sync_rst),
  .bit_in   (bit_in),
  .run_hit  (run_hit),
  .state    (state)
);

// File: tb/triple_one_detector_tb.sv
module triple_one_detector_tb;

  logic clk_i = 1'b0;
  logic sync_rst = 1'b1;
  logic bit_in = 1'b0;
  logic run_hit;

  int n_checks = 0;
  int n_fail = 0;
  int model_cnt = 0;
  bit last_hit = 1'b0;

  always #5 clk_i = ~clk_i;

  triple_one_detector u_dut (
    .clk_i    (clk_i),
    .sync_rst (sync_rst),
    .bit_in   (bit_in),
    .run_hit  (run_hit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: run_hit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, check the Mealy output, then advance the model at the rising edge.
  task automatic step(input logic r, input logic b, input string tag_in);
    string tag;
    logic exp;
    @(negedge clk_i);
    sync_rst = r;
    bit_in = b;
    #1;
    exp = !r && (model_cnt == 2) && b;
    if (tag_in != "") tag = tag_in;
    else if (r) tag = "R1/R6";
    else if (!b) tag = "R4";
    else if (model_cnt == 2) tag = "R3";
    else if (last_hit) tag = "R5";
    else tag = "R2";
    check(tag, run_hit, exp);
    last_hit = exp;
    if (r || !b || model_cnt == 2) model_cnt = 0;
    else model_cnt = model_cnt + 1;
  endtask

  initial begin
    step(1'b1, 1'b0, "R1");
    // directed walk through each transition
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R3");
    // R5: fourth 1 silent, hit every third bit of a long run
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, "R5");
    // R6: reset with a 1 while the count is two
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");
    // R7: sweep of every pattern up to eight bits, plain and with a reset on the last bit
    for (int len = 1; len <= 8; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        for (int rl = 0; rl < 2; rl++) begin
          step(1'b1, 1'b0, "");
          for (int k = 0; k < len; k++)
            step((rl == 1) && (k == len - 1), pat[k], "");
        end
      end
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule